// File: doc/BRIEF.md
# Byte-Latched Program Counter

This block holds the fetch address of a small 8-bit controller core. The address is 21 bits wide and points at bytes. Instructions are two bytes long, so the address is always even. Software can reach only the lowest byte of the address through its register port. The two upper parts are changed through a pair of holding registers, called the high shadow and the upper shadow.

Writing the low byte moves both shadows into the upper parts of the address on the same clock edge. Reading the low byte does the opposite: it copies the current upper parts of the address into the shadows, so software can then look at them. Software can read and write the shadows freely. Doing so has no effect on the fetch address until the next low-byte write.

Apart from the register port, the core drives two other controls. A step strobe moves the address on to the next instruction. A direct-load port carries the full target of a jump, call or branch; this path ignores the shadows entirely.

Top module: `fetch_addr_unit`

## Requirements
- R1: When `rst` is high at a clock edge, the fetch address, the high shadow and the upper shadow all become 0.
- R2: With `reg_sel` = 2'b00, `reg_rdata` shows `fetch_addr[7:0]`. A write with `reg_sel` = 2'b00 sets `fetch_addr[7:1]` to `reg_wdata[7:1]`.
- R3: A low-byte write (`reg_wr`=1, `reg_sel`=2'b00) has two more effects on the same edge: `fetch_addr[15:8]` takes the high shadow, and `fetch_addr[20:16]` takes bits 4:0 of the upper shadow.
- R4: A low-byte read (`reg_rd`=1, `reg_sel`=2'b00) copies `fetch_addr[15:8]` into the high shadow and `fetch_addr[20:16]` into the upper shadow on that edge. The fetch address does not change.
- R5: `fetch_addr[0]` is always 0, and low-byte reads return bit 0 as 0. This holds even when `reg_wdata[0]` or `load_addr[0]` is 1.
- R6: When `step`=1 and neither a low-byte write nor a load is active, the fetch address goes up by 2. It wraps from 0x1FFFFE to 0.
- R7: When `load`=1, the fetch address becomes `load_addr` with bit 0 cleared. Both shadows keep their values.
- R8: If several updates arrive in the same cycle, the order of priority is: low-byte write first, then direct load, then step.
- R9: The upper shadow keeps only 5 bits. With `reg_sel`=2'b10, `reg_rdata[7:5]` reads 0.
- R10: Register select codes: 2'b01 is the high shadow, 2'b10 is the upper shadow, 2'b11 is unused. A write to a shadow changes only that shadow. A write with 2'b11 changes nothing, and reads with 2'b11 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 00 low byte, 01 high shadow, 10 upper shadow, 11 unused |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the low byte fills the shadows) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| step | input | 1 | Move on to the next instruction (+2) |
| load | input | 1 | Direct load strobe for jump, call and branch |
| load_addr | input | 21 | Target address for a direct load |
| fetch_addr | output | 21 | Current fetch address |

## Verification
Some properties are checked by assertions on every cycle:
- bit 0 of the address stays 0;
- the address changes by exactly +2 on a step;
- the address is held when no update is active;
- a low-byte write puts both shadows into the address;
- a low-byte read fills the shadows;
- the priority decode is followed;
- the upper shadow reads back with zero padding.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the shadows staying unchanged across a direct load;
- the wrap from the top of the address space to 0;
- the unused select code changing nothing;
- a full round trip, where shadows written by software reach the address, are replaced by a load, and are read back through the capture path.

// File: rtl/fau_pkg.sv
package fau_pkg;

    parameter int unsigned PC_W   = 21;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned HI_W  = BYTE_W;
    localparam int unsigned UP_W  = PC_W - 2 * BYTE_W;
    localparam int unsigned HI_LSB = BYTE_W;
    localparam int unsigned UP_LSB = 2 * BYTE_W;

    typedef enum logic [1:0] {
        SEL_LOW   = 2'b00,
        SEL_HIGH  = 2'b01,
        SEL_UPPER = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_COMMIT,
        UPD_LOAD,
        UPD_STEP
    } upd_e;

    typedef struct packed {
        logic [UP_W-1:0] up;
        logic [HI_W-1:0] hi;
    } shadow_t;

    function automatic logic [PC_W-1:0] even_addr(input logic [PC_W-1:0] a);
        return a & ~PC_W'(1);
    endfunction

    function automatic logic [BYTE_W-1:0] even_byte(input logic [BYTE_W-1:0] b);
        return b & ~BYTE_W'(1);
    endfunction

endpackage

// File: rtl/fau_ctrl.sv
module fau_ctrl
    import fau_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_sel_e sel,
    input  logic     wr,
    input  logic     rd,
    input  logic     step,
    input  logic     load,
    output upd_e     upd,
    output logic     wr_hi,
    output logic     wr_up,
    output logic     capture
);

    logic lo_wr;
    assign lo_wr = wr && (sel == SEL_LOW);

    always_comb begin
        if (lo_wr)      upd = UPD_COMMIT;
        else if (load)  upd = UPD_LOAD;
        else if (step)  upd = UPD_STEP;
        else            upd = UPD_HOLD;
    end

    assign wr_hi   = wr && (sel == SEL_HIGH);
    assign wr_up   = wr && (sel == SEL_UPPER);
    assign capture = rd && (sel == SEL_LOW);

    // R8: software write of the low byte wins over load and step
    p_prio_commit_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_LOW) |-> (upd == UPD_COMMIT));
    p_prio_load_r8: assert property (@(posedge clk) disable iff (rst)
        (load && !(wr && sel == SEL_LOW)) |-> (upd == UPD_LOAD));
    // R10: at most one shadow written per cycle
    p_one_shadow_wr_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_hi, wr_up, capture}));

endmodule

// File: rtl/fau_shadow.sv
module fau_shadow
    import fau_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hi,
    input  logic            wr_up,
    input  logic            capture,
    input  logic [HI_W-1:0] wdata_hi,
    input  logic [UP_W-1:0] wdata_up,
    input  logic [HI_W-1:0] cnt_hi,
    input  logic [UP_W-1:0] cnt_up,
    output shadow_t         sh
);

    shadow_t sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (capture) begin
            sh_q.hi <= cnt_hi;
            sh_q.up <= cnt_up;
        end else begin
            if (wr_hi) sh_q.hi <= wdata_hi;
            if (wr_up) sh_q.up <= wdata_up;
        end
    end

    assign sh = sh_q;

    // R4: a low-byte read fills both shadows from the counter
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        capture |=> (sh_q.hi == $past(cnt_hi)) && (sh_q.up == $past(cnt_up)));
    // R10: shadows hold when untouched
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(capture || wr_hi || wr_up) |=> $stable(sh_q));
    // R1: reset clears the shadows
    p_shadow_reset_r1: assert property (@(posedge clk)
        rst |=> (sh_q == '0));

endmodule

// File: rtl/fau_counter.sv
module fau_counter
    import fau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  upd_e              upd,
    input  logic [BYTE_W-1:0] lo_wdata,
    input  shadow_t           sh,
    input  logic [PC_W-1:0]   load_addr,
    output logic [PC_W-1:0]   cnt
);

    logic [PC_W-1:0] cnt_q;
    logic [PC_W-1:0] commit_val;
    logic [PC_W-1:0] nxt;

    assign commit_val = {sh.up, sh.hi, even_byte(lo_wdata)};

    always_comb begin
        unique case (upd)
            UPD_COMMIT: nxt = commit_val;
            UPD_LOAD:   nxt = even_addr(load_addr);
            UPD_STEP:   nxt = cnt_q + PC_W'(2);
            default:    nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt;
    end

    assign cnt = cnt_q;

    // R5: fetch address is always even
    p_even_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q[0] == 1'b0);
    // R6: step adds two, modulo the address width
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (upd == UPD_STEP) |=> (cnt_q == $past(cnt_q) + PC_W'(2)));
    // R3: a low-byte write commits both shadows into the upper parts
    p_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (upd == UPD_COMMIT) |=> (cnt_q[PC_W-1:UP_LSB] == $past(sh.up))
                              && (cnt_q[UP_LSB-1:HI_LSB] == $past(sh.hi)));
    // R7: a direct load replaces the whole address except bit 0
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (upd == UPD_LOAD) |=> (cnt_q[PC_W-1:1] == $past(load_addr[PC_W-1:1])));
    // R4: nothing but an update changes the address
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (upd == UPD_HOLD) |=> $stable(cnt_q));
    // R1: reset clears the address
    p_cnt_reset_r1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

endmodule

// File: rtl/fau_rdmux.sv
module fau_rdmux
    import fau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] lo,
    input  shadow_t           sh,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        unique case (sel)
            SEL_LOW:   rdata = lo;
            SEL_HIGH:  rdata = sh.hi;
            SEL_UPPER: rdata = BYTE_W'(sh.up);
            default:   rdata = '0;
        endcase
    end

    // R9: upper shadow is padded with zeros
    p_up_pad_r9: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_UPPER) |-> (rdata[BYTE_W-1:UP_W] == '0));
    // R5: the low byte reads back even
    p_lo_even_r5: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_LOW) |-> (rdata[0] == 1'b0));

endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
    import fau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              step,
    input  logic              load,
    input  logic [PC_W-1:0]   load_addr,
    output logic [PC_W-1:0]   fetch_addr
);

    reg_sel_e sel_e;
    upd_e     upd;
    logic     wr_hi, wr_up, capture;
    shadow_t  sh;
    logic [PC_W-1:0] cnt;

    assign sel_e = reg_sel_e'(reg_sel);

    fau_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_e),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .step    (step),
        .load    (load),
        .upd     (upd),
        .wr_hi   (wr_hi),
        .wr_up   (wr_up),
        .capture (capture)
    );

    fau_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_hi    (wr_hi),
        .wr_up    (wr_up),
        .capture  (capture),
        .wdata_hi (reg_wdata[HI_W-1:0]),
        .wdata_up (reg_wdata[UP_W-1:0]),
        .cnt_hi   (cnt[UP_LSB-1:HI_LSB]),
        .cnt_up   (cnt[PC_W-1:UP_LSB]),
        .sh       (sh)
    );

    fau_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .lo_wdata  (reg_wdata),
        .sh        (sh),
        .load_addr (load_addr),
        .cnt       (cnt)
    );

    fau_rdmux u_rdmux (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel_e),
        .lo    (cnt[BYTE_W-1:0]),
        .sh    (sh),
        .rdata (reg_rdata)
    );

    assign fetch_addr = cnt;

    // R4: a low-byte read leaves the fetch address alone
    p_read_keeps_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == 2'b00 && !reg_wr && !load && !step) |=> $stable(fetch_addr));

endmodule

// File: tb/fetch_addr_unit_bench.sv
`timescale 1ns/1ps
module fetch_addr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'b00;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        step = 1'b0;
    logic        load = 1'b0;
    logic [20:0] load_addr = '0;
    logic [20:0] fetch_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_addr_unit u_fetch_addr_unit (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step(step), .load(load),
        .load_addr(load_addr), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at a falling edge and removed at the next
    task automatic drive(input logic [1:0] s, input logic w, input logic r, input logic [7:0] d,
                         input logic st, input logic ld, input logic [20:0] la);
        @(negedge clk);
        reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = d;
        step = st; load = ld; load_addr = la;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; step = 1'b0; load = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 addr after reset", 32'(fetch_addr), 32'h0);
        peek(2'b01, v); chk("R1 high shadow after reset", 32'(v), 32'h0);
        peek(2'b10, v); chk("R1 upper shadow after reset", 32'(v), 32'h0);
    endtask

    task automatic t_step;
        logic [7:0] v;
        for (int i = 0; i < 3; i++) drive(2'b00, 0, 0, 8'h00, 1, 0, '0);
        chk("R6 three steps", 32'(fetch_addr), 32'h6);
        peek(2'b00, v); chk("R2 low byte read", 32'(v), 32'h06);
    endtask

    task automatic t_shadow;
        logic [7:0] v;
        drive(2'b01, 1, 0, 8'h12, 0, 0, '0);
        drive(2'b10, 1, 0, 8'hFF, 0, 0, '0);
        peek(2'b10, v); chk("R9 upper shadow padded", 32'(v), 32'h1F);
        peek(2'b01, v); chk("R10 high shadow written", 32'(v), 32'h12);
        chk("R10 shadow writes leave addr", 32'(fetch_addr), 32'h6);
        drive(2'b11, 1, 0, 8'h55, 0, 0, '0);
        peek(2'b11, v); chk("R10 unused code reads zero", 32'(v), 32'h0);
        chk("R10 unused write leaves addr", 32'(fetch_addr), 32'h6);
        peek(2'b01, v); chk("R10 unused write leaves high", 32'(v), 32'h12);
        peek(2'b10, v); chk("R10 unused write leaves upper", 32'(v), 32'h1F);
    endtask

    task automatic t_commit;
        logic [7:0] v;
        drive(2'b00, 1, 0, 8'h35, 0, 0, '0);
        chk("R3 commit of shadows", 32'(fetch_addr), 32'h1F1234);
        peek(2'b00, v); chk("R5 low byte bit0 cleared", 32'(v), 32'h34);
    endtask

    task automatic t_load;
        logic [7:0] v;
        drive(2'b00, 0, 0, 8'h00, 0, 1, 21'h0ABCD1);
        chk("R7 direct load", 32'(fetch_addr), 32'h0ABCD0);
        peek(2'b01, v); chk("R7 load keeps high shadow", 32'(v), 32'h12);
        peek(2'b10, v); chk("R7 load keeps upper shadow", 32'(v), 32'h1F);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        @(negedge clk);
        reg_sel = 2'b00; reg_rd = 1'b1;
        #1;
        chk("R2 low byte read data", 32'(reg_rdata), 32'hD0);
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R4 read leaves addr", 32'(fetch_addr), 32'h0ABCD0);
        peek(2'b01, v); chk("R4 high captured", 32'(v), 32'hBC);
        peek(2'b10, v); chk("R4 upper captured", 32'(v), 32'h0A);
    endtask

    task automatic t_wrap;
        drive(2'b00, 0, 0, 8'h00, 0, 1, 21'h1FFFFE);
        chk("R6 top of range", 32'(fetch_addr), 32'h1FFFFE);
        drive(2'b00, 0, 0, 8'h00, 1, 0, '0);
        chk("R6 wrap to zero", 32'(fetch_addr), 32'h0);
    endtask

    task automatic t_prio;
        drive(2'b00, 1, 0, 8'h40, 1, 1, 21'h000100);
        chk("R8 write beats load and step", 32'(fetch_addr), 32'h0ABC40);
        drive(2'b00, 0, 0, 8'h00, 1, 1, 21'h000200);
        chk("R8 load beats step", 32'(fetch_addr), 32'h000200);
    endtask

    task automatic t_reset_mid;
        logic [7:0] v;
        drive(2'b00, 0, 0, 8'h00, 1, 0, '0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mid-run reset addr", 32'(fetch_addr), 32'h0);
        peek(2'b01, v); chk("R1 mid-run reset high", 32'(v), 32'h0);
        peek(2'b10, v); chk("R1 mid-run reset upper", 32'(v), 32'h0);
    endtask

    initial begin
        t_reset;
        t_step;
        t_shadow;
        t_commit;
        t_load;
        t_capture;
        t_wrap;
        t_prio;
        t_reset_mid;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule